// File: doc/BRIEF.md
# Four-State Hard-Decision Viterbi Decoder

This block decodes a rate-1/2 convolutional code with constraint length 3, using hard decisions. One 2-bit symbol arrives every clock. The block forms a Hamming-distance branch metric for every trellis branch and runs add-compare-select over the four states. It keeps a window of per-state survivor choices and traces back through that window from the best state. Each cycle it delivers one decoded bit together with a qualifying valid flag.

Decoding runs in blocks. A one-cycle sync pulse, issued by the surrounding system, throws away the trellis history and restarts from the all-zero state. Each sync also flips the block between free-run and self-test. In free-run the symbols come from the input port. In self-test an internal pseudo-random source and encoder supply the symbols instead. A reference bit, delayed to line up with the decoded bit, is compared with the decoder output, and any mismatch raises a fail flag. The packed path metrics, the latest decision vector and the oldest decision column in the window are brought out for observation.

Top module: `vit4_decoder`

## Requirements
- R1: The code uses a 2-bit state {s1,s0}. For a data bit b, the emitted symbol is {y2,y1} = {b^s0, b^s1^s0}, and the next state is {b,s1}. The symbol input and the internal stream both use this convention.
- R2: After reset, and in the cycle after a cycle with syncIn high, pathMetrics reads 16'hFFF0 and validOut is low. The metric of state k sits in bits [4k+3:4k], so state 0 starts at 0 and every other state starts at 15. The symbol presented in the sync cycle is not decoded.
- R3: The branch metric is the Hamming distance between the received symbol and the branch symbol. State n has the predecessors {n[0],0} and {n[0],1}. Bit n of decisions is 1 only when the second predecessor has the strictly smaller sum, so a tie selects the first. After a sync followed by symbol 00, pathMetrics reads 16'hF2F0 and decisions reads 4'b0000.
- R4: After each step the minimum metric is subtracted from all four, and any result above 15 is clamped to 15. At least one state therefore always holds metric 0.
- R5: The n-th step after a sync is the n-th cycle after the sync cycle. After step t, for t >= 17, bitOut carries the decoded bit of step t-16. The traceback starts at the lowest-numbered state that has the minimum metric. For an error-free symbol stream, bitOut equals the data bit of step t-16.
- R6: validOut is low from a sync until step 16 and goes high after step 17. It then stays high until the next sync.
- R7: Single symbol-bit errors spaced at least 20 steps apart are corrected, so bitOut still equals the transmitted data.
- R8: The mode is free-run out of reset and flips at every sync. In self-test, symIn is ignored and the internally encoded stream is decoded.
- R9: On sync the internal 8-bit generator q loads 8'h01. Each step it advances to {q[6:1], q[7]^q[0], q[7]}, and q[7] is the data bit of that step. After step t, refBitOut equals the data bit of step t-16. The generator runs in both modes.
- R10: failOut equals validOut AND (bitOut XOR refBitOut), in both modes.
- R11: After step t, for t >= 16, survColumn equals the decisions value that was shown after step t-15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| syncIn | input | 1 | Block restart pulse; also flips the mode |
| symIn | input | 2 | Received hard-decision symbol {y2,y1} |
| bitOut | output | 1 | Decoded bit from the traceback |
| validOut | output | 1 | bitOut is meaningful |
| failOut | output | 1 | Decoded bit differs from the reference bit |
| refBitOut | output | 1 | Delayed internal data bit |
| pathMetrics | output | 16 | Four packed 4-bit path metrics, state 0 lowest |
| decisions | output | 4 | Survivor-select bits of the latest step |
| survColumn | output | 4 | Oldest decision column in the traceback window |

## Verification
The decoder is first driven with clean encoded random data in free-run. This shows that the encoder convention, the add-compare-select and the 16-step traceback alignment all agree. Isolated flipped symbol bits then separate a decoder that truly selects survivors from one that only inverts the encoding. The self-test blocks drive garbage on symIn. Correct output there proves that the internal stream is selected and that the reference delay is exact. In free-run, fail must follow the mismatch between the random data and the generator. A directed first symbol of 00 exposes the tie rule and the clamp, and a short block confirms that valid never rises before the window fills.

// File: rtl/vit4_pkg.sv
package vit4_pkg;

  typedef struct packed {
    logic init;
    logic step;
  } ctlStrobe_t;

  function automatic logic [1:0] branchSym(input logic [1:0] pred, input logic b);
    return {b ^ pred[0], b ^ pred[1] ^ pred[0]};
  endfunction

  function automatic logic [1:0] hamDist(input logic [1:0] a, input logic [1:0] c);
    logic [1:0] x;
    x = a ^ c;
    return {x[0] & x[1], x[0] ^ x[1]};
  endfunction

endpackage

// File: rtl/vit4_ctrl.sv
module vit4_ctrl
  import vit4_pkg::*;
#(
  parameter int TB = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncIn,
  output ctlStrobe_t strobe,
  output logic       selfMode,
  output logic       validOut
);
  localparam int FULL = TB + 1;
  localparam int CW = $clog2(FULL + 1);

  logic [CW-1:0] stepCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepCnt  <= '0;
      selfMode <= 1'b0;
    end else begin
      selfMode <= selfMode ^ syncIn;
      if (syncIn) stepCnt <= '0;
      else if (stepCnt != CW'(FULL)) stepCnt <= stepCnt + 1'b1;
    end
  end

  assign strobe.init = syncIn;
  assign strobe.step = ~syncIn;
  assign validOut    = (stepCnt == CW'(FULL));

endmodule

// File: rtl/vit4_datapath.sv
module vit4_datapath
  import vit4_pkg::*;
#(
  parameter int MW = 4,
  parameter int TB = 16,
  parameter int PW = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  ctlStrobe_t     strobe,
  input  logic           selfMode,
  input  logic [1:0]     symIn,
  output logic           bitOut,
  output logic           refBitOut,
  output logic [4*MW-1:0] pathMetrics,
  output logic [3:0]     decisions,
  output logic [3:0]     survColumn
);
  localparam int NS = 4;
  localparam int EW = MW + 2;
  localparam logic [MW-1:0] MAXM = {MW{1'b1}};
  localparam logic [PW-1:0] SEED = PW'(1);

  // self-test source and encoder
  logic [PW-1:0] prng;
  logic [1:0]    encState;
  logic [TB:0]   refSh;
  logic          dataBit;
  logic [1:0]    selfSym, rxSym;

  assign dataBit = prng[PW-1];
  assign selfSym = {dataBit ^ encState[0], dataBit ^ encState[1] ^ encState[0]};
  assign rxSym   = selfMode ? selfSym : symIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prng     <= SEED;
      encState <= '0;
      refSh    <= '0;
    end else begin
      refSh <= {refSh[TB-1:0], dataBit};
      if (strobe.init) begin
        prng     <= SEED;
        encState <= '0;
      end else begin
        prng     <= {prng[PW-2:1], prng[PW-1] ^ prng[0], prng[PW-1]};
        encState <= {dataBit, encState[1]};
      end
    end
  end
  assign refBitOut = refSh[TB];

  // add-compare-select
  logic [MW-1:0] pm   [NS];
  logic [EW-1:0] surv [NS];
  logic [MW-1:0] norm [NS];
  logic [NS-1:0] sel;
  logic [EW-1:0] minV;
  logic [1:0]    bestNext, bestState;

  for (genvar n = 0; n < NS; n++) begin : g_acs
    localparam logic [1:0] P0 = 2'((n % 2) * 2);
    localparam logic [1:0] P1 = 2'((n % 2) * 2 + 1);
    localparam logic       BIN = 1'(n / 2);
    logic [EW-1:0] cand0, cand1;
    assign cand0   = EW'(pm[P0]) + EW'(hamDist(rxSym, branchSym(P0, BIN)));
    assign cand1   = EW'(pm[P1]) + EW'(hamDist(rxSym, branchSym(P1, BIN)));
    assign sel[n]  = (cand1 < cand0);
    assign surv[n] = sel[n] ? cand1 : cand0;
    assign pathMetrics[n*MW +: MW] = pm[n];
  end

  always_comb begin
    logic [EW-1:0] diff;
    minV = surv[0];
    for (int k = 1; k < NS; k++)
      if (surv[k] < minV) minV = surv[k];
    for (int k = 0; k < NS; k++) begin
      diff    = surv[k] - minV;
      norm[k] = (diff > EW'(MAXM)) ? MAXM : diff[MW-1:0];
    end
    bestNext = 2'd0;
    for (int k = 1; k < NS; k++)
      if (norm[k] < norm[bestNext]) bestNext = 2'(k);
  end

  // survivor window
  logic [NS-1:0] hist [TB];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NS; k++) pm[k] <= (k == 0) ? '0 : MAXM;
      for (int k = 0; k < TB; k++) hist[k] <= '0;
      bestState <= '0;
    end else if (strobe.init) begin
      for (int k = 0; k < NS; k++) pm[k] <= (k == 0) ? '0 : MAXM;
      bestState <= '0;
    end else if (strobe.step) begin
      for (int k = 0; k < NS; k++) pm[k] <= norm[k];
      hist[0] <= sel;
      for (int k = 1; k < TB; k++) hist[k] <= hist[k-1];
      bestState <= bestNext;
    end
  end

  // traceback
  always_comb begin
    logic [1:0] st;
    st = bestState;
    for (int k = 0; k < TB; k++)
      st = {st[0], hist[k][st]};
    bitOut = st[1];
  end

  assign decisions  = hist[0];
  assign survColumn = hist[TB-1];

endmodule

// File: rtl/vit4_decoder.sv
module vit4_decoder
  import vit4_pkg::*;
#(
  parameter int MW = 4,
  parameter int TB = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            syncIn,
  input  logic [1:0]      symIn,
  output logic            bitOut,
  output logic            validOut,
  output logic            failOut,
  output logic            refBitOut,
  output logic [4*MW-1:0] pathMetrics,
  output logic [3:0]      decisions,
  output logic [3:0]      survColumn
);
  ctlStrobe_t strobe;
  logic       selfMode;

  vit4_ctrl #(.TB(TB)) u_ctrl (
    .clk(clk), .rstN(rstN), .syncIn(syncIn),
    .strobe(strobe), .selfMode(selfMode), .validOut(validOut)
  );

  vit4_datapath #(.MW(MW), .TB(TB), .PW(8)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .selfMode(selfMode),
    .symIn(symIn), .bitOut(bitOut), .refBitOut(refBitOut),
    .pathMetrics(pathMetrics), .decisions(decisions), .survColumn(survColumn)
  );

  assign failOut = validOut & (bitOut ^ refBitOut);

endmodule

// File: rtl/vit4_checker.sv
module vit4_checker #(
  parameter int MW = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            syncIn,
  input logic            validOut,
  input logic            failOut,
  input logic [4*MW-1:0] pathMetrics
);
  localparam logic [4*MW-1:0] INITPM = {{(3*MW){1'b1}}, {MW{1'b0}}};

  logic anyZero;
  always_comb begin
    anyZero = 1'b0;
    for (int k = 0; k < 4; k++)
      if (pathMetrics[k*MW +: MW] == '0) anyZero = 1'b1;
  end

  // R2
  sync_init_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncIn |=> (pathMetrics == INITPM) && !validOut);

  // R4
  min_zero_chk: assert property (@(posedge clk) disable iff (!rstN) anyZero);

  // R10
  fail_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    failOut |-> validOut);

  // R6
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    validOut && !syncIn |=> validOut);

  // R6
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(validOut) |-> $past(!syncIn));

endmodule

bind vit4_decoder vit4_checker #(.MW(MW)) u_chk (
  .clk(clk), .rstN(rstN), .syncIn(syncIn), .validOut(validOut),
  .failOut(failOut), .pathMetrics(pathMetrics)
);

// File: tb/vit4_decoder_bench.sv
module vit4_decoder_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        syncIn = 1'b0;
  logic [1:0]  symIn = 2'b00;
  logic        bitOut, validOut, failOut, refBitOut;
  logic [15:0] pathMetrics;
  logic [3:0]  decisions, survColumn;

  int checks = 0;
  int errors = 0;
  logic expMode = 1'b0;
  logic       dat   [0:127];
  logic       refd  [0:127];
  logic [3:0] decH  [0:127];

  vit4_decoder u_vit4_decoder (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .symIn(symIn),
    .bitOut(bitOut), .validOut(validOut), .failOut(failOut),
    .refBitOut(refBitOut), .pathMetrics(pathMetrics),
    .decisions(decisions), .survColumn(survColumn)
  );

  always #2 clk = ~clk;

  function automatic logic [1:0] encSym(input logic b, input logic [1:0] es);
    return {b ^ es[0], b ^ es[1] ^ es[0]};
  endfunction

  function automatic logic [7:0] genNext(input logic [7:0] q);
    return {q[6:1], q[7] ^ q[0], q[7]};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runBlock(input int nSteps, input int errA, input int errB, input int errC);
    logic [7:0] q;
    logic [1:0] es, s;
    logic d;
    expMode = ~expMode;
    syncIn = 1'b1;
    symIn  = 2'($urandom);
    @(negedge clk);
    chk(pathMetrics == 16'hFFF0, "R2 metrics after sync", pathMetrics, 16'hFFF0);
    chk(validOut == 1'b0, "R2 valid after sync", validOut, 0);
    syncIn = 1'b0;
    q  = 8'h01;
    es = 2'b00;
    for (int t = 1; t <= nSteps; t++) begin
      if (expMode) begin
        d = q[7];
        s = encSym(d, es);
        symIn = 2'($urandom);
      end else begin
        d = 1'($urandom);
        s = encSym(d, es);
        if (t == errA || t == errB || t == errC) s = s ^ (2'b01 << ($urandom % 2));
        symIn = s;
      end
      dat[t]  = d;
      refd[t] = q[7];
      es = {d, es[1]};
      q  = genNext(q);
      @(negedge clk);
      decH[t] = decisions;
      if (t == 1 && s == 2'b00) begin
        chk(pathMetrics == 16'hF2F0, "R3 metrics step1", pathMetrics, 16'hF2F0);
        chk(decisions == 4'b0000, "R3 tie decisions", decisions, 0);
      end
      chk((pathMetrics[3:0] == 0) || (pathMetrics[7:4] == 0) ||
          (pathMetrics[11:8] == 0) || (pathMetrics[15:12] == 0),
          "R4 zero minimum", pathMetrics, 0);
      chk(validOut == (t >= 17), "R6 valid timing", validOut, (t >= 17));
      if (t >= 16)
        chk(survColumn == decH[t-15], "R11 oldest column", survColumn, decH[t-15]);
      if (t >= 17) begin
        if (expMode)
          chk(bitOut == dat[t-16], "R8 R1 self-test decode", bitOut, dat[t-16]);
        else if (errA > 0)
          chk(bitOut == dat[t-16], "R7 corrected decode", bitOut, dat[t-16]);
        else
          chk(bitOut == dat[t-16], "R1 R5 clean decode", bitOut, dat[t-16]);
        chk(refBitOut == refd[t-16], "R9 reference bit", refBitOut, refd[t-16]);
        chk(failOut == (dat[t-16] != refd[t-16]), "R10 fail flag", failOut,
            (dat[t-16] != refd[t-16]));
      end
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(pathMetrics == 16'hFFF0, "R2 reset metrics", pathMetrics, 16'hFFF0);
    chk(validOut == 1'b0, "R2 reset valid", validOut, 0);
    chk(failOut == 1'b0, "R10 reset fail", failOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    runBlock(100, 0, 0, 0);    // self-test, garbage on symIn
    runBlock(100, 0, 0, 0);    // free-run, clean
    runBlock(100, 0, 0, 0);    // self-test
    runBlock(100, 30, 55, 80); // free-run, isolated errors
    runBlock(10, 0, 0, 0);     // short self-test block
    runBlock(60, 0, 0, 0);     // free-run
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule